// File: doc/BRIEF.md
# L2 MAC Hash Bucket Lookup

This block searches a layer-2 forwarding table for a station. It combines a 48-bit MAC address and a 12-bit VLAN/filter ID into a 60-bit seed and folds the seed into an 11-bit hash key. The low bits of that key select a bucket. Every bucket holds four entries, one in each way of the table, and all four are compared in the same cycle. The result says whether the station was found and in which way. On a hit it also gives the stored forwarding fields: egress port, static flag, age, source and destination block flags, suspended flag and next-hop flag. It also reports the lowest empty way of the bucket, for learning, or a full flag when the bucket has no empty way.

Two hash algorithms are available and `hash_mode` picks one. The plain mode XORs fixed slices of the seed. The rotating mode first rotates three of those slices. Software maintains the table through a host port that addresses one entry by bucket and way. Host accesses take priority over lookups, and `lk_ready` drops while one is in progress. The table is held in one synchronous-read memory per way, so a lookup result arrives a fixed two cycles after the request is accepted.

Top module: `l2h_lookup`

## Requirements
- R1: With `hash_mode` = 0 the seed is {mac, vid} (mac in bits 59:12, vid in bits 11:0). `res_hash` is the XOR of seed slices 10:0, 21:11, 32:22, 43:33 and 54:44, together with slice 59:55 zero-extended to 11 bits.
- R2: With `hash_mode` = 1 three slices are rotated before the same XOR. Slice 21:11 becomes {its bits 4:0, its bits 10:5}. Slice 43:33 becomes {bits 5:0, bits 10:6}. Slice 54:44 becomes {bits 6:0, bits 10:7}. The other slices are used unchanged.
- R3: The bucket searched is `res_hash[BKT_AW-1:0]`, and it holds ways 0 to 3 as written by the host port.
- R4: An entry word on `host_wdata`/`host_rdata` is laid out as mac[73:26], vid[25:14], port[13:9], static[8], age[7:6], block-source[5], block-destination[4], suspended[3], next-hop[2], ip-multicast[1] and ipv6-multicast[0]. An entry is valid when static, any age bit, either multicast flag, either block flag or next-hop is set. The suspended flag alone does not make an entry valid, and an entry that is not valid counts as empty.
- R5: A hit needs a valid entry whose stored mac and vid both equal the request. When several ways match, the lowest-numbered way is reported.
- R6: On a hit, `res_way` and the port, static, age, block, suspended and next-hop outputs carry the matching entry. On a miss, all of these outputs are zero.
- R7: `res_free_way` is the lowest-numbered empty way of the bucket. `res_full` is 1 exactly when none of the four ways is empty.
- R8: A lookup is accepted in a cycle where `lk_req` and `lk_ready` are both high. Its result shows on `res_valid` and the result outputs for exactly one cycle, two cycles later. Lookups may be accepted back to back and their results come out in order. The result reflects the table as it stood in the cycle the lookup was accepted.
- R9: `lk_ready` is low in any cycle where `host_we` or `host_re` is high. A request in such a cycle is not accepted and produces no result.
- R10: A host write stores `host_wdata` at (`host_bucket`, `host_way`). A host read (with `host_we` low) returns that entry on `host_rdata`, with `host_rvalid` high, one cycle later. A read in the same cycle as a write is dropped.
- R11: After reset every entry is empty, `res_valid` and `host_rvalid` are low and `lk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_mode | input | 1 | 0 = plain slice XOR, 1 = rotated slices |
| lk_req | input | 1 | Lookup request |
| lk_mac | input | 48 | Requested MAC address |
| lk_vid | input | 12 | Requested VLAN/filter ID |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_bucket | input | BKT_AW | Host bucket address |
| host_way | input | 2 | Host way address |
| host_wdata | input | 74 | Entry word to write |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 74 | Entry word read |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Station found |
| res_way | output | 2 | Matching way |
| res_free_way | output | 2 | Lowest empty way |
| res_full | output | 1 | No empty way in bucket |
| res_hash | output | 11 | Hash key of the request |
| res_port | output | 5 | Stored egress port |
| res_static | output | 1 | Stored static flag |
| res_age | output | 2 | Stored age |
| res_blk_sa | output | 1 | Stored source-block flag |
| res_blk_da | output | 1 | Stored destination-block flag |
| res_susp | output | 1 | Stored suspended flag |
| res_nh | output | 1 | Stored next-hop flag |

## Verification
A lookup driven in cycle c is due on the result outputs only in cycle c+2: one register stage is the memory read and one is the compare. The bench sets its stimulus on a falling edge and lets two rising edges pass before it compares the outputs on the next falling edge. It also checks that `res_valid` is low again one cycle later. Host read data is due one cycle after the strobe and is sampled after a single rising edge. For a request refused by `lk_ready`, the bench samples both cycles in which a result could appear and confirms that none does.

// File: rtl/l2h_pkg.sv
package l2h_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int KEY_W  = 11;
  localparam int WAYS   = 4;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int PORT_W = 5;

  typedef struct packed {
    logic [MAC_W-1:0]  mac;
    logic [VID_W-1:0]  vid;
    logic [PORT_W-1:0] port;
    logic              stat;
    logic [1:0]        age;
    logic              blk_sa;
    logic              blk_da;
    logic              susp;
    logic              nh;
    logic              ipmc;
    logic              ip6mc;
  } l2h_ent_t;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              stat;
    logic [1:0]        age;
    logic              blk_sa;
    logic              blk_da;
    logic              susp;
    logic              nh;
  } l2h_info_t;

  localparam int ENT_W  = $bits(l2h_ent_t);
  localparam int INFO_W = $bits(l2h_info_t);

  // Fold the 60-bit {mac, vid} seed into the hash key; rot selects rotated slices.
  function automatic logic [KEY_W-1:0] l2h_hash(input logic [MAC_W-1:0] mac,
                                                input logic [VID_W-1:0] vid,
                                                input logic rot);
    logic [MAC_W+VID_W-1:0] s;
    logic [10:0] p0, p1, p2, p3, p4;
    logic [4:0]  p5;
    s  = {mac, vid};
    p0 = s[10:0];
    p1 = s[21:11];
    p2 = s[32:22];
    p3 = s[43:33];
    p4 = s[54:44];
    p5 = s[59:55];
    if (rot) begin
      p1 = {p1[4:0], p1[10:5]};
      p3 = {p3[5:0], p3[10:6]};
      p4 = {p4[6:0], p4[10:7]};
    end
    return p0 ^ p1 ^ p2 ^ p3 ^ p4 ^ {6'd0, p5};
  endfunction

  // No explicit valid bit: an entry is live when any marker field is set.
  function automatic logic l2h_valid(input l2h_ent_t e);
    return e.stat | (|e.age) | e.ipmc | e.ip6mc | e.blk_sa | e.blk_da | e.nh;
  endfunction
endpackage

// File: rtl/l2h_way_ram.sv
module l2h_way_ram
  import l2h_pkg::*;
#(
  parameter int BKT_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BKT_AW-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [BKT_AW-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  localparam int NBKT = 1 << BKT_AW;

  logic [ENT_W-1:0] mem [NBKT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBKT; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/l2h_way_cmp.sv
module l2h_way_cmp
  import l2h_pkg::*;
(
  input  logic [ENT_W-1:0]  ent,
  input  logic [MAC_W-1:0]  mac,
  input  logic [VID_W-1:0]  vid,
  output logic              hit,
  output logic              empty,
  output logic [INFO_W-1:0] info
);
  l2h_ent_t  e;
  l2h_info_t fi;
  logic      live;

  assign e     = l2h_ent_t'(ent);
  assign live  = l2h_valid(e);
  assign hit   = live && (e.mac == mac) && (e.vid == vid);
  assign empty = !live;

  always_comb begin
    fi = '{port: e.port, stat: e.stat, age: e.age, blk_sa: e.blk_sa,
           blk_da: e.blk_da, susp: e.susp, nh: e.nh};
    info = hit ? INFO_W'(fi) : '0;
  end
endmodule

// File: rtl/l2h_lookup.sv
module l2h_lookup
  import l2h_pkg::*;
#(
  parameter int BKT_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hash_mode,
  input  logic              lk_req,
  input  logic [47:0]       lk_mac,
  input  logic [11:0]       lk_vid,
  output logic              lk_ready,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [BKT_AW-1:0] host_bucket,
  input  logic [1:0]        host_way,
  input  logic [73:0]       host_wdata,
  output logic              host_rvalid,
  output logic [73:0]       host_rdata,
  output logic              res_valid,
  output logic              res_hit,
  output logic [1:0]        res_way,
  output logic [1:0]        res_free_way,
  output logic              res_full,
  output logic [10:0]       res_hash,
  output logic [4:0]        res_port,
  output logic              res_static,
  output logic [1:0]        res_age,
  output logic              res_blk_sa,
  output logic              res_blk_da,
  output logic              res_susp,
  output logic              res_nh
);
  // Named events used by the assertions
  logic lk_fire, hrd_fire;
  assign lk_ready = !(host_we || host_re);
  assign lk_fire  = lk_req && lk_ready;
  assign hrd_fire = host_re && !host_we;

  logic [KEY_W-1:0]  hash_now;
  logic [BKT_AW-1:0] rd_bkt;
  assign hash_now = l2h_hash(lk_mac, lk_vid, hash_mode);
  assign rd_bkt   = host_re ? host_bucket : hash_now[BKT_AW-1:0];

  // Stage 1: request key travels alongside the synchronous memory read
  logic              s1_lk, s1_hrd;
  logic [MAC_W-1:0]  s1_mac;
  logic [VID_W-1:0]  s1_vid;
  logic [KEY_W-1:0]  s1_hash;
  logic [WAY_W-1:0]  s1_hway;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_lk   <= 1'b0;
      s1_hrd  <= 1'b0;
      s1_mac  <= '0;
      s1_vid  <= '0;
      s1_hash <= '0;
      s1_hway <= '0;
    end else begin
      s1_lk  <= lk_fire;
      s1_hrd <= hrd_fire;
      if (lk_fire) begin
        s1_mac  <= lk_mac;
        s1_vid  <= lk_vid;
        s1_hash <= hash_now;
      end
      if (hrd_fire) s1_hway <= host_way;
    end
  end

  logic [ENT_W-1:0]  rd_all [WAYS];
  logic [INFO_W-1:0] info_all [WAYS];
  logic [WAYS-1:0]   hit_v, empty_v;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    l2h_way_ram #(.BKT_AW(BKT_AW)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (host_we && (host_way == WAY_W'(g))),
      .waddr (host_bucket),
      .wdata (host_wdata),
      .raddr (rd_bkt),
      .rdata (rd_all[g])
    );
    l2h_way_cmp u_cmp (
      .ent   (rd_all[g]),
      .mac   (s1_mac),
      .vid   (s1_vid),
      .hit   (hit_v[g]),
      .empty (empty_v[g]),
      .info  (info_all[g])
    );
  end

  assign host_rvalid = s1_hrd;
  assign host_rdata  = rd_all[s1_hway];

  // Priority pick: lowest hit way and lowest empty way
  logic             hit_any;
  logic [WAY_W-1:0] hit_idx, free_idx;
  l2h_info_t        hit_info;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_v[w]) begin
        hit_any = 1'b1;
        hit_idx = WAY_W'(w);
      end
      if (empty_v[w]) free_idx = WAY_W'(w);
    end
    hit_info = l2h_info_t'(info_all[hit_idx]);
  end

  // Stage 2: registered result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_way      <= '0;
      res_free_way <= '0;
      res_full     <= 1'b0;
      res_hash     <= '0;
      res_port     <= '0;
      res_static   <= 1'b0;
      res_age      <= '0;
      res_blk_sa   <= 1'b0;
      res_blk_da   <= 1'b0;
      res_susp     <= 1'b0;
      res_nh       <= 1'b0;
    end else begin
      res_valid <= s1_lk;
      if (s1_lk) begin
        res_hit      <= hit_any;
        res_way      <= hit_idx;
        res_free_way <= free_idx;
        res_full     <= ~|empty_v;
        res_hash     <= s1_hash;
        res_port     <= hit_info.port;
        res_static   <= hit_info.stat;
        res_age      <= hit_info.age;
        res_blk_sa   <= hit_info.blk_sa;
        res_blk_da   <= hit_info.blk_da;
        res_susp     <= hit_info.susp;
        res_nh       <= hit_info.nh;
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> ##1 res_valid); // R8
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_fire, 2)); // R8
  AST_HOST_BLOCKS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> ##1 !res_valid); // R9
  AST_HOST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    hrd_fire |=> host_rvalid); // R10
  AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_port == '0 && !res_static && res_age == '0 && res_way == '0)); // R6
  AST_FREE_NOT_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !res_full) |-> (res_free_way != res_way)); // R7
endmodule

// File: tb/tb_l2h_lookup.sv
module tb_l2h_lookup;
  localparam int BKT_AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hash_mode = 1'b0;
  logic lk_req = 1'b0;
  logic [47:0] lk_mac = '0;
  logic [11:0] lk_vid = '0;
  logic lk_ready;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [BKT_AW-1:0] host_bucket = '0;
  logic [1:0] host_way = '0;
  logic [73:0] host_wdata = '0;
  logic host_rvalid;
  logic [73:0] host_rdata;
  logic res_valid, res_hit, res_full, res_static, res_blk_sa, res_blk_da, res_susp, res_nh;
  logic [1:0] res_way, res_free_way, res_age;
  logic [10:0] res_hash;
  logic [4:0] res_port;

  always #5 clk = ~clk;

  l2h_lookup #(.BKT_AW(BKT_AW)) dut (
    .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode), .lk_req(lk_req),
    .lk_mac(lk_mac), .lk_vid(lk_vid), .lk_ready(lk_ready),
    .host_we(host_we), .host_re(host_re), .host_bucket(host_bucket),
    .host_way(host_way), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .res_valid(res_valid), .res_hit(res_hit),
    .res_way(res_way), .res_free_way(res_free_way), .res_full(res_full),
    .res_hash(res_hash), .res_port(res_port), .res_static(res_static),
    .res_age(res_age), .res_blk_sa(res_blk_sa), .res_blk_da(res_blk_da),
    .res_susp(res_susp), .res_nh(res_nh)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference hash, written with shifts and masks on a 64-bit seed
  function automatic logic [10:0] ref_hash(logic [47:0] mac, logic [11:0] vid, bit m);
    longint unsigned s;
    int unsigned a, b, c, d, e, f, h;
    s = (longint'(mac) << 12) | longint'(vid);
    a = 32'(s & 64'h7ff);
    b = 32'((s >> 11) & 64'h7ff);
    c = 32'((s >> 22) & 64'h7ff);
    d = 32'((s >> 33) & 64'h7ff);
    e = 32'((s >> 44) & 64'h7ff);
    f = 32'((s >> 55) & 64'h1ff);
    if (m) begin
      b = ((b & 32'h1f) << 6) | ((b >> 5) & 32'h3f);
      d = ((d & 32'h3f) << 5) | ((d >> 6) & 32'h1f);
      e = ((e & 32'h7f) << 4) | ((e >> 7) & 32'hf);
    end
    h = a ^ b ^ c ^ d ^ e ^ f;
    return h[10:0];
  endfunction

  function automatic logic [73:0] mk(logic [47:0] mac, logic [11:0] vid, logic [4:0] port,
      bit st, logic [1:0] age, bit bsa, bit bda, bit sus, bit nh, bit ipm, bit ip6);
    return {mac, vid, port, st, age, bsa, bda, sus, nh, ipm, ip6};
  endfunction

  task automatic hwrite(logic [BKT_AW-1:0] b, logic [1:0] w, logic [73:0] d);
    @(negedge clk);
    host_we = 1; host_bucket = b; host_way = w; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic lookup(logic [47:0] mac, logic [11:0] vid, bit m);
    @(negedge clk);
    lk_req = 1; lk_mac = mac; lk_vid = vid; hash_mode = m;
    @(negedge clk);
    lk_req = 0;
    @(negedge clk); // two rising edges after acceptance
  endtask

  task automatic expect_res(string tag, bit hit, logic [1:0] way, logic [4:0] port, bit st,
      logic [1:0] age, bit bsa, bit bda, logic [1:0] fw, bit full);
    check({tag, " valid"}, 80'(res_valid), 80'(1));
    check({tag, " hit"}, 80'(res_hit), 80'(hit));
    check({tag, " way"}, 80'(res_way), 80'(way));
    check({tag, " fields"}, 80'({res_port, res_static, res_age, res_blk_sa, res_blk_da}),
          80'({port, st, age, bsa, bda}));
    check({tag, " free/full"}, 80'({res_free_way, res_full}), 80'({fw, full}));
  endtask

  localparam logic [60:0] VEC [6] = '{
    {1'b0, 48'h001A2B3C4D5E, 12'h064},
    {1'b0, 48'hFFFFFFFFFFFF, 12'hFFF},
    {1'b0, 48'h800000000001, 12'h800},
    {1'b1, 48'h001A2B3C4D5E, 12'h064},
    {1'b1, 48'h0123456789AB, 12'h7A5},
    {1'b1, 48'hF0F0F0F00F0F, 12'h003}
  };

  localparam logic [47:0] KM = 48'h001A2B3C4D5E;

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [BKT_AW-1:0] bk;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 res_valid in reset", 80'(res_valid), 80'(0));
    check("R11 host_rvalid in reset", 80'(host_rvalid), 80'(0));
    rst_n = 1;
    @(negedge clk);
    check("R11 lk_ready after reset", 80'(lk_ready), 80'(1));

    // Vector table: hashes in both modes on an empty table (R1, R2, R11)
    for (int i = 0; i < 6; i++) begin
      logic m; logic [47:0] mc; logic [11:0] vd;
      {m, mc, vd} = VEC[i];
      lookup(mc, vd, m);
      check(m ? "R2 rotated hash" : "R1 plain hash", 80'(res_hash), 80'(ref_hash(mc, vd, m)));
      expect_res("R11 empty table", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end

    bk = ref_hash(KM, 12'h064, 0)[BKT_AW-1:0];
    // R4: suspended-only entry is not valid; R3: entry placed in bucket from hash low bits
    hwrite(bk, 0, mk(KM, 12'h064, 5'd9, 0, 0, 0, 0, 1, 0, 0, 0));
    hwrite(bk, 2, mk(KM, 12'h064, 5'd7, 1, 0, 0, 1, 0, 0, 0, 0));
    lookup(KM, 12'h064, 0);
    expect_res("R3 R4 R5 R6 hit way2", 1, 2, 5'd7, 1, 0, 0, 1, 0, 0);
    check("R6 susp/nh on hit", 80'({res_susp, res_nh}), 80'(0));
    @(negedge clk);
    check("R8 result is one-cycle pulse", 80'(res_valid), 80'(0));

    // R10 host readback
    @(negedge clk);
    host_re = 1; host_bucket = bk; host_way = 2;
    @(negedge clk);
    host_re = 0;
    check("R10 host_rvalid", 80'(host_rvalid), 80'(1));
    check("R10 host_rdata", 80'(host_rdata), 80'(mk(KM, 12'h064, 5'd7, 1, 0, 0, 1, 0, 0, 0, 0)));

    // R5 VID mismatch in same bucket misses
    lookup(KM, 12'h044, 0);
    expect_res("R5 vid mismatch", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R3 same bucket", 80'(res_hash[BKT_AW-1:0]), 80'(bk));

    // R5 duplicate keys: lowest way wins
    hwrite(bk, 1, mk(KM, 12'h064, 5'd3, 0, 2, 1, 0, 0, 0, 0, 0));
    lookup(KM, 12'h064, 0);
    expect_res("R5 lowest way", 1, 1, 5'd3, 0, 2, 1, 0, 0, 0);

    // R4 next-hop-only and ipmc-only entries count as valid; R7 full bucket
    hwrite(bk, 0, mk(KM, 12'h044, 5'd0, 0, 0, 0, 0, 0, 1, 0, 0));
    hwrite(bk, 3, mk(KM, 12'h024, 5'd0, 0, 0, 0, 0, 0, 0, 1, 0));
    lookup(KM, 12'h004, 0);
    expect_res("R7 full bucket miss", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    lookup(KM, 12'h044, 0);
    expect_res("R4 next-hop valid", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R6 next-hop flag", 80'(res_nh), 80'(1));

    // R4 all-zero row is empty; R7 free way returns to 0
    hwrite(bk, 0, '0);
    lookup(KM, 12'h004, 0);
    expect_res("R7 free way 0", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R9 host write stalls a lookup
    @(negedge clk);
    lk_req = 1; lk_mac = KM; lk_vid = 12'h064; hash_mode = 0;
    host_we = 1; host_bucket = bk ^ 5'd1; host_way = 0; host_wdata = '0;
    #1 check("R9 lk_ready low on write", 80'(lk_ready), 80'(0));
    @(negedge clk);
    lk_req = 0; host_we = 0;
    check("R9 no result cycle1", 80'(res_valid), 80'(0));
    @(negedge clk);
    check("R9 no result cycle2", 80'(res_valid), 80'(0));

    // R8 back-to-back lookups in order
    @(negedge clk);
    lk_req = 1; lk_mac = KM; lk_vid = 12'h064;
    @(negedge clk);
    lk_vid = 12'h024;
    @(negedge clk);
    lk_req = 0;
    expect_res("R8 first of pair", 1, 1, 5'd3, 0, 2, 1, 0, 0, 0);
    @(negedge clk);
    check("R8 second valid", 80'(res_valid), 80'(1));
    check("R8 second way", 80'({res_hit, res_way}), 80'({1'b1, 2'd3}));
    @(negedge clk);
    check("R8 pair ends", 80'(res_valid), 80'(0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule